// File: doc/BRIEF.md
# Variable-Length Instruction Predecoder

This block sits between an instruction byte fetch path and a decode stage of a processor that uses 16-bit instruction words. Bytes arrive one per handshake, most significant byte first. The block gathers the two bytes of the leading word and inspects them. That inspection tells it whether the instruction is complete at two bytes or needs a trailing 32-bit immediate, which makes it six bytes long. Once an instruction is complete, it is presented as a single record on a valid/ready output port.

Each record carries the following:
- the start address of the instruction
- the word and the immediate
- the length
- a format class
- the opcode index
- the register fields
- the 8-bit immediate of the short-immediate form
- an illegal-encoding flag
- for relative branches, the computed target address

After each record is captured, the start address moves forward by that record's length. A flush input loads a new address and throws away any bytes already gathered. It also drops a record still waiting at the output. The block does not execute anything, keep flags or evaluate branch conditions.

Top module: `ifp_predecode`

## Requirements
- R1: A word with bit 15 clear is form 1. The opcode output is bits 14..8, register A is bits 7..4 and register B is bits 3..0. The word output equals the two leading bytes, first byte in bits 15..8.
- R2: A word whose bits 15..14 are 2'b10 is form 2. The opcode output is bits 13..12 zero-extended, register A is bits 11..8, register B is 0, and the 8-bit immediate output is bits 7..0. For every other form the 8-bit immediate output is 0.
- R3: A word whose bits 15..14 are 2'b11 is form 3. The opcode output is bits 13..10 and both register outputs are 0. The target is the start address plus 2 plus bits 9..0 sign-extended and multiplied by 2, modulo 2^ADDR_W. For forms 1 and 2 the target is 0.
- R4: Form 1 opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36 to 0x39 are 6 bytes long. Their immediate is the next four bytes, first byte in bits 31..24. Every other word is 2 bytes long with an immediate output of 0.
- R5: The class output codes are as follows:
  - 0: no operand (form 1 opcodes 0x00, 0x04, 0x35)
  - 1: register A only (0x19, 0x25)
  - 2: A and B (all remaining legal form 1 opcodes)
  - 3: A with immediate (0x01, 0x08, 0x1B, 0x1D, 0x20, 0x22)
  - 4: immediate only (0x03, 0x1A, 0x30)
  - 5: immediate then A (0x09, 0x1F, 0x24)
  - 6: indirect with displacement (0x0C, 0x0D, 0x36 to 0x39)
  - 7: form 2
  - 8: legal form 3
  - 15: illegal
- R6: Form 1 opcodes 0x0F to 0x18 and 0x3A to 0x7F, and form 3 opcodes 0x0A to 0x0F, are illegal. They raise the illegal output, report class 15 and are 2 bytes long.
- R7: Each record's address equals the previous record's address plus the previous record's length.
- R8: A flush clears the output valid, discards partly gathered bytes, and sets the address of the next record to the flush address.
- R9: While a record is valid and not accepted, byte ready is low and the record stays unchanged. Every byte is used exactly once, in order.
- R10: After reset, output valid is low and the first record carries address RESET_ADDR (0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard gathered bytes and reload the address |
| flush_addr_i | input | ADDR_W | Address loaded by a flush |
| byte_valid_i | input | 1 | Input byte valid |
| byte_data_i | input | 8 | Input byte |
| byte_ready_o | output | 1 | Byte accepted when high with valid |
| ins_valid_o | output | 1 | Record valid |
| ins_ready_i | input | 1 | Record accepted when high with valid |
| ins_addr_o | output | ADDR_W | Start address of the instruction |
| ins_word_o | output | 16 | Leading instruction word |
| ins_imm_o | output | 32 | Trailing immediate, 0 if none |
| ins_len_o | output | 3 | Length in bytes (2 or 6) |
| ins_class_o | output | 4 | Format class code |
| ins_opcode_o | output | 7 | Opcode index of the form |
| ins_rega_o | output | 4 | Register A field |
| ins_regb_o | output | 4 | Register B field |
| ins_imm8_o | output | 8 | Form 2 short immediate |
| ins_target_o | output | ADDR_W | Relative branch target |
| ins_illegal_o | output | 1 | Undefined encoding |

## Verification
A byte counter that slips by even one position does not give a single bad record and then recover. Every later record comes out with the wrong word, the wrong length and a shifted immediate, starting from the very next record. A wrong address register shows up as an address gap on the next record, and it also skews that record's branch target. A broken flush appears as a stale record or a misaligned word on the first record after the flush. Random byte gaps are combined with heavy output stall so that any lost or repeated byte breaks the record-by-record comparison.

// File: rtl/ifp_pkg.sv
package ifp_pkg;

  localparam int WORD_W    = 16;
  localparam int IMM_BYTES = 4;
  localparam int IMM_W     = IMM_BYTES * 8;
  localparam int LEN_W     = 3;

  typedef enum logic [3:0] {
    CL_NONE    = 4'd0,
    CL_A       = 4'd1,
    CL_AB      = 4'd2,
    CL_AIMM    = 4'd3,
    CL_IMM     = 4'd4,
    CL_IMMA    = 4'd5,
    CL_DISP    = 4'd6,
    CL_REGIMM8 = 4'd7,
    CL_BRANCH  = 4'd8,
    CL_ILLEGAL = 4'd15
  } ifp_class_e;

  function automatic ifp_class_e ifp_classify(input logic [WORD_W-1:0] w);
    ifp_class_e c;
    if (!w[15]) begin
      case (w[14:8]) inside
        7'h00, 7'h04, 7'h35:                      c = CL_NONE;
        7'h19, 7'h25:                             c = CL_A;
        7'h01, 7'h08, 7'h1B, 7'h1D, 7'h20, 7'h22: c = CL_AIMM;
        7'h03, 7'h1A, 7'h30:                      c = CL_IMM;
        7'h09, 7'h1F, 7'h24:                      c = CL_IMMA;
        7'h0C, 7'h0D, [7'h36:7'h39]:              c = CL_DISP;
        [7'h0F:7'h18], [7'h3A:7'h7F]:             c = CL_ILLEGAL;
        default:                                  c = CL_AB;
      endcase
    end else if (!w[14]) begin
      c = CL_REGIMM8;
    end else begin
      c = (w[13:10] > 4'h9) ? CL_ILLEGAL : CL_BRANCH;
    end
    return c;
  endfunction

  function automatic logic ifp_has_imm(input ifp_class_e c);
    return c inside {CL_AIMM, CL_IMM, CL_IMMA, CL_DISP};
  endfunction

endpackage

// File: rtl/ifp_field_decode.sv
module ifp_field_decode
  import ifp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] addr_i,
  output ifp_class_e        cls_o,
  output logic [6:0]        opcode_o,
  output logic [3:0]        rega_o,
  output logic [3:0]        regb_o,
  output logic [7:0]        imm8_o,
  output logic [ADDR_W-1:0] target_o
);

  localparam int EXT_W = ADDR_W - 11;

  logic [ADDR_W-1:0] rel_ofs;

  always_comb begin
    cls_o    = ifp_classify(word_i);
    rel_ofs  = {{EXT_W{word_i[9]}}, word_i[9:0], 1'b0};
    opcode_o = '0;
    rega_o   = '0;
    regb_o   = '0;
    imm8_o   = '0;
    target_o = '0;
    if (!word_i[15]) begin
      opcode_o = word_i[14:8];
      rega_o   = word_i[7:4];
      regb_o   = word_i[3:0];
    end else if (!word_i[14]) begin
      opcode_o = {5'd0, word_i[13:12]};
      rega_o   = word_i[11:8];
      imm8_o   = word_i[7:0];
    end else begin
      opcode_o = {3'd0, word_i[13:10]};
      target_o = addr_i + ADDR_W'(2) + rel_ofs;
    end
  end

endmodule

// File: rtl/ifp_collect.sv
module ifp_collect
  import ifp_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic              byte_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_word_o,
  output logic [IMM_W-1:0]  out_imm_o,
  output logic [LEN_W-1:0]  out_len_o,
  output logic [ADDR_W-1:0] out_addr_o
);

  localparam int LAST    = 1 + IMM_BYTES;
  localparam int CNT_W   = $clog2(LAST + 1);
  localparam int PART_W  = (IMM_BYTES - 1) * 8;
  localparam int LONG_LEN = 2 + IMM_BYTES;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [7:0]        hi_q, hi_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [PART_W-1:0] part_q, part_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] ow_q, ow_d;
  logic [IMM_W-1:0]  oi_q, oi_d;
  logic [LEN_W-1:0]  ol_q, ol_d;
  logic [ADDR_W-1:0] oa_q, oa_d;
  logic [WORD_W-1:0] cand;
  logic              take;

  assign byte_ready_o = !flush_i && (!vld_q || out_ready_i);
  assign take         = byte_valid_i && byte_ready_o;
  assign cand         = {hi_q, byte_data_i};

  always_comb begin
    cnt_d  = cnt_q;
    hi_d   = hi_q;
    word_d = word_q;
    part_d = part_q;
    pc_d   = pc_q;
    vld_d  = vld_q && !out_ready_i;
    ow_d   = ow_q;
    oi_d   = oi_q;
    ol_d   = ol_q;
    oa_d   = oa_q;
    if (flush_i) begin
      cnt_d = '0;
      pc_d  = flush_addr_i;
      vld_d = 1'b0;
    end else if (take) begin
      if (cnt_q == '0) begin
        hi_d  = byte_data_i;
        cnt_d = CNT_W'(1);
      end else if (cnt_q == CNT_W'(1)) begin
        if (ifp_has_imm(ifp_classify(cand))) begin
          word_d = cand;
          cnt_d  = CNT_W'(2);
        end else begin
          ow_d  = cand;
          oi_d  = '0;
          ol_d  = LEN_W'(2);
          oa_d  = pc_q;
          pc_d  = pc_q + ADDR_W'(2);
          vld_d = 1'b1;
          cnt_d = '0;
        end
      end else if (cnt_q == CNT_W'(LAST)) begin
        ow_d  = word_q;
        oi_d  = {part_q, byte_data_i};
        ol_d  = LEN_W'(LONG_LEN);
        oa_d  = pc_q;
        pc_d  = pc_q + ADDR_W'(LONG_LEN);
        vld_d = 1'b1;
        cnt_d = '0;
      end else begin
        part_d = {part_q[PART_W-9:0], byte_data_i};
        cnt_d  = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pc_q  <= RESET_ADDR;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pc_q  <= pc_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      hi_q   <= hi_d;
      word_q <= word_d;
      part_q <= part_d;
      ow_q   <= ow_d;
      oi_q   <= oi_d;
      ol_q   <= ol_d;
      oa_q   <= oa_d;
    end
  end

  assign out_valid_o = vld_q;
  assign out_word_o  = ow_q;
  assign out_imm_o   = oi_q;
  assign out_len_o   = ol_q;
  assign out_addr_o  = oa_q;

  // R9: a stalled record stays put
  a_r9_record_held: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !out_ready_i && !flush_i |=> vld_q && $stable(ow_q) && $stable(oa_q) && $stable(oi_q));

  // R4: only two lengths ever leave
  a_r4_len_two_or_six: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (ol_q == LEN_W'(2)) || (ol_q == LEN_W'(LONG_LEN)));

  // R4: the byte counter never passes the last immediate byte
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LAST));

  // R8: a flush leaves no record and no partial bytes
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !vld_q && (cnt_q == '0));

endmodule

// File: rtl/ifp_predecode.sv
module ifp_predecode
  import ifp_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic              byte_ready_o,
  output logic              ins_valid_o,
  input  logic              ins_ready_i,
  output logic [ADDR_W-1:0] ins_addr_o,
  output logic [15:0]       ins_word_o,
  output logic [31:0]       ins_imm_o,
  output logic [2:0]        ins_len_o,
  output logic [3:0]        ins_class_o,
  output logic [6:0]        ins_opcode_o,
  output logic [3:0]        ins_rega_o,
  output logic [3:0]        ins_regb_o,
  output logic [7:0]        ins_imm8_o,
  output logic [ADDR_W-1:0] ins_target_o,
  output logic              ins_illegal_o
);

  ifp_class_e cls;

  ifp_collect #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_collect (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .flush_addr_i(flush_addr_i),
    .byte_valid_i(byte_valid_i),
    .byte_data_i (byte_data_i),
    .byte_ready_o(byte_ready_o),
    .out_valid_o (ins_valid_o),
    .out_ready_i (ins_ready_i),
    .out_word_o  (ins_word_o),
    .out_imm_o   (ins_imm_o),
    .out_len_o   (ins_len_o),
    .out_addr_o  (ins_addr_o)
  );

  ifp_field_decode #(.ADDR_W(ADDR_W)) u_fields (
    .word_i  (ins_word_o),
    .addr_i  (ins_addr_o),
    .cls_o   (cls),
    .opcode_o(ins_opcode_o),
    .rega_o  (ins_rega_o),
    .regb_o  (ins_regb_o),
    .imm8_o  (ins_imm8_o),
    .target_o(ins_target_o)
  );

  assign ins_class_o   = cls;
  assign ins_illegal_o = (cls == CL_ILLEGAL);

  // R4 / R5: the length chosen while collecting agrees with the class
  a_r4_len_matches_class: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid_o |-> ((ins_len_o == 3'd6) == ifp_has_imm(cls)));

  // R6: illegal encodings are always short
  a_r6_illegal_short: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid_o && ins_illegal_o |-> ins_len_o == 3'd2);

  // R3: a branch target keeps the halfword alignment of its start address
  a_r3_target_parity: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid_o && ins_word_o[15] && ins_word_o[14] |-> ins_target_o[0] == ins_addr_o[0]);

endmodule

// File: tb/test_ifp_predecode.sv
module test_ifp_predecode;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic [31:0] flush_addr_i = '0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_data_i = '0;
  logic        byte_ready_o;
  logic        ins_valid_o;
  logic        ins_ready_i = 1'b0;
  logic [31:0] ins_addr_o;
  logic [15:0] ins_word_o;
  logic [31:0] ins_imm_o;
  logic [2:0]  ins_len_o;
  logic [3:0]  ins_class_o;
  logic [6:0]  ins_opcode_o;
  logic [3:0]  ins_rega_o;
  logic [3:0]  ins_regb_o;
  logic [7:0]  ins_imm8_o;
  logic [31:0] ins_target_o;
  logic        ins_illegal_o;

  always #2 clk = ~clk;

  ifp_predecode i_ifp_predecode (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i), .byte_ready_o(byte_ready_o),
    .ins_valid_o(ins_valid_o), .ins_ready_i(ins_ready_i), .ins_addr_o(ins_addr_o),
    .ins_word_o(ins_word_o), .ins_imm_o(ins_imm_o), .ins_len_o(ins_len_o),
    .ins_class_o(ins_class_o), .ins_opcode_o(ins_opcode_o), .ins_rega_o(ins_rega_o),
    .ins_regb_o(ins_regb_o), .ins_imm8_o(ins_imm8_o), .ins_target_o(ins_target_o),
    .ins_illegal_o(ins_illegal_o)
  );

  int checks = 0;
  int failures = 0;

  logic [7:0]  bq [0:4095];
  int          bq_n = 0;
  int          bq_i = 0;
  logic [15:0] ew [0:1023];
  logic [31:0] ei [0:1023];
  logic [31:0] ea [0:1023];
  int          en = 0;
  int          eo = 0;
  logic [31:0] model_pc = 32'd0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_cls(input logic [15:0] w);
    int op;
    if (w[15] == 1'b0) begin
      op = int'(w[14:8]);
      if ((op >= 8'h0F && op <= 8'h18) || op >= 8'h3A) return 15;
      if (op == 8'h00 || op == 8'h04 || op == 8'h35) return 0;
      if (op == 8'h19 || op == 8'h25) return 1;
      if (op == 8'h01 || op == 8'h08 || op == 8'h1B || op == 8'h1D || op == 8'h20 || op == 8'h22) return 3;
      if (op == 8'h03 || op == 8'h1A || op == 8'h30) return 4;
      if (op == 8'h09 || op == 8'h1F || op == 8'h24) return 5;
      if (op == 8'h0C || op == 8'h0D || (op >= 8'h36 && op <= 8'h39)) return 6;
      return 2;
    end
    if (w[14] == 1'b0) return 7;
    return (int'(w[13:10]) >= 10) ? 15 : 8;
  endfunction

  function automatic int exp_len(input logic [15:0] w);
    int c;
    c = exp_cls(w);
    return (c >= 3 && c <= 6) ? 6 : 2;
  endfunction

  function automatic logic [31:0] exp_target(input logic [15:0] w, input logic [31:0] a);
    int off;
    if (w[15:14] != 2'b11) return 32'd0;
    off = int'(w[9:0]);
    if (off >= 512) off = off - 1024;
    return a + 32'd2 + 32'(off * 2);
  endfunction

  task automatic push_instr(input logic [15:0] w, input logic [31:0] imm);
    int l;
    l = exp_len(w);
    ea[en] = model_pc;
    ew[en] = w;
    ei[en] = (l == 6) ? imm : 32'd0;
    bq[bq_n] = w[15:8];
    bq[bq_n+1] = w[7:0];
    bq_n += 2;
    if (l == 6) begin
      for (int k = 3; k >= 0; k--) begin
        bq[bq_n] = imm[k*8 +: 8];
        bq_n++;
      end
    end
    model_pc = model_pc + 32'(l);
    en++;
  endtask

  task automatic check_rec(input int k);
    logic [15:0] w;
    w = ew[k];
    chk("R1", "word", 32'(ins_word_o), 32'(w));
    chk((k == 0) ? "R10" : "R7", "addr", ins_addr_o, ea[k]);
    chk("R4", "len", 32'(ins_len_o), 32'(exp_len(w)));
    chk("R4", "imm", ins_imm_o, ei[k]);
    chk("R5", "class", 32'(ins_class_o), 32'(exp_cls(w)));
    chk("R6", "illegal", 32'(ins_illegal_o), 32'(exp_cls(w) == 15));
    chk("R3", "target", ins_target_o, exp_target(w, ea[k]));
    if (!w[15]) begin
      chk("R1", "opcode", 32'(ins_opcode_o), 32'(w[14:8]));
      chk("R1", "rega", 32'(ins_rega_o), 32'(w[7:4]));
      chk("R1", "regb", 32'(ins_regb_o), 32'(w[3:0]));
      chk("R2", "imm8", 32'(ins_imm8_o), 32'd0);
    end else if (!w[14]) begin
      chk("R2", "opcode", 32'(ins_opcode_o), 32'(w[13:12]));
      chk("R2", "rega", 32'(ins_rega_o), 32'(w[11:8]));
      chk("R2", "regb", 32'(ins_regb_o), 32'd0);
      chk("R2", "imm8", 32'(ins_imm8_o), 32'(w[7:0]));
    end else begin
      chk("R3", "opcode", 32'(ins_opcode_o), 32'(w[13:10]));
      chk("R3", "regs", 32'({ins_rega_o, ins_regb_o}), 32'd0);
    end
  endtask

  task automatic run_all(input int gap_pct, input int stall_pct);
    while (bq_i < bq_n || eo < en) begin
      @(posedge clk);
      #1;
      byte_valid_i = (bq_i < bq_n) && (($urandom % 100) >= gap_pct);
      byte_data_i  = bq[bq_i];
      ins_ready_i  = ($urandom % 100) >= stall_pct;
      @(negedge clk);
      if (ins_valid_o && !ins_ready_i) chk("R9", "byte_ready_in_stall", 32'(byte_ready_o), 32'd0);
      if (byte_valid_i && byte_ready_o) bq_i++;
      if (ins_valid_o && ins_ready_i) begin
        if (eo < en) check_rec(eo);
        else chk("R9", "extra_record", 32'd1, 32'd0);
        eo++;
      end
    end
    @(posedge clk);
    #1;
    byte_valid_i = 1'b0;
  endtask

  task automatic raw_byte(input logic [7:0] b);
    do begin
      @(posedge clk);
      #1;
      byte_valid_i = 1'b1;
      byte_data_i  = b;
      @(negedge clk);
    end while (!byte_ready_o);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "valid_in_reset", 32'(ins_valid_o), 32'd0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "valid_after_reset", 32'(ins_valid_o), 32'd0);

    // directed corner words
    push_instr(16'h0000, 32'h0);
    push_instr(16'h0123, 32'hDEADBEEF);
    push_instr(16'h0F00, 32'h0);
    push_instr(16'h1800, 32'h0);
    push_instr(16'h1900, 32'h0);
    push_instr(16'h3A00, 32'h0);
    push_instr(16'h7F55, 32'h0);
    push_instr(16'h3977, 32'h01020304);
    push_instr(16'h9ABC, 32'h0);
    push_instr(16'hC200, 32'h0);
    push_instr(16'hC1FF, 32'h0);
    push_instr(16'hE800, 32'h0);
    push_instr(16'hFC00, 32'h0);
    push_instr(16'h0300, 32'hA5A55A5A);
    push_instr(16'h0945, 32'h80000001);
    push_instr(16'h2E12, 32'h0);
    run_all(0, 0);

    for (int n = 0; n < 250; n++) push_instr(16'($urandom), $urandom);
    run_all(30, 40);
    for (int n = 0; n < 60; n++) push_instr(16'($urandom), $urandom);
    run_all(10, 90);

    // R9: explicit stall with a waiting record
    ins_ready_i = 1'b0;
    raw_byte(8'h05);
    raw_byte(8'h21);
    @(posedge clk);
    #1;
    byte_valid_i = 1'b0;
    @(negedge clk);
    chk("R9", "stalled_valid", 32'(ins_valid_o), 32'd1);
    chk("R9", "stalled_ready", 32'(byte_ready_o), 32'd0);

    // R8: flush drops the waiting record
    @(posedge clk);
    #1;
    flush_i = 1'b1;
    flush_addr_i = 32'h1000;
    @(posedge clk);
    #1;
    flush_i = 1'b0;
    @(negedge clk);
    chk("R8", "valid_after_flush", 32'(ins_valid_o), 32'd0);

    // R8: flush discards a partial long instruction
    ins_ready_i = 1'b1;
    raw_byte(8'h01);
    raw_byte(8'h20);
    raw_byte(8'hAA);
    @(posedge clk);
    #1;
    byte_valid_i = 1'b0;
    flush_i = 1'b1;
    flush_addr_i = 32'h2000;
    @(posedge clk);
    #1;
    flush_i = 1'b0;
    model_pc = 32'h2000;
    push_instr(16'h2E12, 32'h0);
    push_instr(16'h0D34, 32'h11223344);
    push_instr(16'hC3FF, 32'h0);
    run_all(0, 0);
    chk("R8", "addr_after_flush_model", model_pc, 32'h2000 + 32'd10);

    summary();
    $finish;
  end

endmodule